// File: doc/BRIEF.md
# Fixed-Rate Serial Port with Vote-Based Receiver

A small full-duplex asynchronous serial port for designs that only need one byte in each direction and a single interrupt. The host writes a byte with a one-cycle strobe and the block sends it on `txd`: a low start bit, eight data bits least significant first, then a high stop bit. When the stop bit has been sent, the block raises a sticky transmit-done flag. The receiver watches `rxd`, recovers a frame of the same format, and places the byte in a holding register that the host reads. It then raises a sticky receive-done flag. The host clears each flag with its own strobe, and `irq` is high while either flag is set.

The bit rate is fixed when the block is built. `CLK_DIV` sets the number of clock cycles per sample tick, and a tick occurs four times per bit. The receiver reads the synchronised line once per tick and decides each bit from its four samples. It has no FIFO, no parity, no flow control and no run-time rate setting.

Top module: `mini_uart`

## Requirements
- R1: After reset, `txd` is 1, `ti`, `ri` and `irq` are 0, and `rd_data` is 0x00.
- R2: A sample tick occurs once every `CLK_DIV` clock cycles, counted from the end of reset. Every transmitted bit lasts four ticks, and `txd` changes only on a tick or when a frame is loaded. The frame is start 0, then data bit 0 first through data bit 7, then stop 1.
- R3: A `wr_en` pulse while the transmitter is idle loads `wr_data`. `txd` goes low after that clock edge, and the start bit ends on the fourth tick after the load.
- R4: A `wr_en` pulse while a frame is being sent, including the cycle in which its stop bit ends, is ignored. No extra frame follows.
- R5: `ti` rises on the clock edge of the fourth tick of the stop bit. From that edge on, `txd` is 1 and a new write is accepted.
- R6: `rxd` passes through a two-stage synchroniser. A frame starts at a tick whose synchronised sample is 0 when the sample at the previous tick was 1. That tick counts as the first of the start bit's four samples.
- R7: Each received bit is the majority of its second, third and fourth samples. The first sample is ignored, so a single wrong sample does not change the bit.
- R8: If the start bit's vote is 1, the receiver returns to idle without setting `ri` and without changing `rd_data`.
- R9: If the stop bit's vote is 1, `rd_data` takes the received byte and `ri` rises on the same edge. If the vote is 0, the frame is dropped and both stay unchanged. `rd_data` never changes at any other time.
- R10: `ti_clr` and `ri_clr` each clear their own flag on the next edge. When a flag is set and cleared in the same cycle, the flag ends up set.
- R11: `irq` is 1 exactly when `ti` or `ri` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| ti_clr | input | 1 | Clear strobe for the transmit-done flag |
| ri_clr | input | 1 | Clear strobe for the receive-done flag |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |
| rd_data | output | 8 | Last byte received with a valid stop bit |
| ti | output | 1 | Transmit-done flag |
| ri | output | 1 | Receive-done flag |
| irq | output | 1 | Interrupt, high while either flag is set |

## Verification
The collision that matters is a flag being set by its engine in the same cycle that the host pulses its clear strobe. The bench holds `ti_clr` high through a whole transmission and `ri_clr` high through a whole reception. It expects each flag to be high for exactly one cycle, because the set wins and the still-active clear removes the flag on the next edge. A second coincidence comes from looping `txd` back into `rxd`: both engines then finish close together, and `irq` must follow both flags, including when they are cleared in the same cycle. A behavioural model driven by the same inputs predicts every output on every clock.

// File: rtl/mini_uart.sv
module mini_uart #(
  parameter int CLK_DIV = 27
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       ti_clr,
  input  logic       ri_clr,
  input  logic       rxd,
  output logic       txd,
  output logic [7:0] rd_data,
  output logic       ti,
  output logic       ri,
  output logic       irq
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0] div_q;
  logic          tick;
  assign tick = (div_q == DW'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  // transmitter
  logic       tx_busy;
  logic [9:0] tx_sh;
  logic [3:0] tx_bit;
  logic [1:0] tx_sub;
  logic       tx_done;

  assign tx_done = tx_busy && tick && (tx_sub == 2'd3) && (tx_bit == 4'd9);
  assign txd     = tx_busy ? tx_sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_bit  <= '0;
      tx_sub  <= '0;
    end else if (wr_en && !tx_busy) begin
      tx_busy <= 1'b1;
      tx_sh   <= {1'b1, wr_data, 1'b0};
      tx_bit  <= '0;
      tx_sub  <= '0;
    end else if (tx_busy && tick) begin
      tx_sub <= tx_sub + 2'd1;
      if (tx_sub == 2'd3) begin
        if (tx_bit == 4'd9) begin
          tx_busy <= 1'b0;
        end else begin
          tx_sh  <= {1'b1, tx_sh[9:1]};
          tx_bit <= tx_bit + 4'd1;
        end
      end
    end
  end

  // receiver
  logic       rx_s1, rx_s2, rx_last;
  logic       rx_on;
  logic [3:0] rx_bit;
  logic [1:0] rx_sub;
  logic [1:0] rx_ones;
  logic [1:0] rx_sum;
  logic       rx_vote;
  logic [7:0] rx_sh;
  logic       rx_done;

  assign rx_sum  = rx_ones + {1'b0, rx_s2};
  assign rx_vote = rx_sum[1];
  assign rx_done = rx_on && tick && (rx_sub == 2'd3) && (rx_bit == 4'd9) && rx_vote;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s1   <= 1'b1;
      rx_s2   <= 1'b1;
      rx_last <= 1'b1;
      rx_on   <= 1'b0;
      rx_bit  <= '0;
      rx_sub  <= '0;
      rx_ones <= '0;
      rx_sh   <= '0;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      if (tick) begin
        rx_last <= rx_s2;
        if (!rx_on) begin
          if (rx_last && !rx_s2) begin
            rx_on   <= 1'b1;
            rx_bit  <= '0;
            rx_sub  <= 2'd1;
            rx_ones <= '0;
          end
        end else if (rx_sub == 2'd3) begin
          rx_sub  <= '0;
          rx_ones <= '0;
          rx_bit  <= rx_bit + 4'd1;
          if (rx_bit == 4'd0 && rx_vote) rx_on <= 1'b0;
          if (rx_bit >= 4'd1 && rx_bit <= 4'd8) rx_sh <= {rx_vote, rx_sh[7:1]};
          if (rx_bit == 4'd9) rx_on <= 1'b0;
        end else begin
          rx_sub  <= rx_sub + 2'd1;
          rx_ones <= rx_ones + {1'b0, (rx_sub != 2'd0) & rx_s2};
        end
      end
    end
  end

  // host side
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      ti      <= 1'b0;
      ri      <= 1'b0;
    end else begin
      if (rx_done) rd_data <= rx_sh;
      if (tx_done)     ti <= 1'b1;
      else if (ti_clr) ti <= 1'b0;
      if (rx_done)     ri <= 1'b1;
      else if (ri_clr) ri <= 1'b0;
    end
  end

  assign irq = ti | ri;
endmodule

// File: rtl/mini_uart_chk.sv
module mini_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       tx_busy,
  input logic       rx_on,
  input logic       txd,
  input logic       ti,
  input logic       ri,
  input logic       ti_clr,
  input logic       ri_clr,
  input logic [7:0] rd_data
);
  // R2 and R4: between ticks a running frame holds its line level, writes included
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tick) |=> $stable(txd));

  assert_ti_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti) |-> (!tx_busy && $past(tx_busy)));

  assert_ti_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ti_clr |=> (!ti || $past(tx_busy)));

  assert_ri_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ri_clr |=> (!ri || $past(rx_on)));

  assert_rd_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> (ri && $past(rx_on)));
endmodule

bind mini_uart mini_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tx_busy(tx_busy), .rx_on(rx_on),
  .txd(txd), .ti(ti), .ri(ri), .ti_clr(ti_clr), .ri_clr(ri_clr), .rd_data(rd_data)
);

// File: tb/tb_mini_uart.sv
`timescale 1ns/1ps
module tb_mini_uart;
  localparam int CLK_DIV = 3;
  localparam int BITCYC  = 4 * CLK_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic ti_clr = 1'b0, ri_clr = 1'b0;
  logic rx_drv = 1'b1, loop = 1'b0;
  logic rxd, txd, ti, ri, irq;
  logic [7:0] rd_data;

  assign rxd = loop ? txd : rx_drv;
  always #2 clk = ~clk;

  mini_uart #(.CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ti_clr(ti_clr), .ri_clr(ri_clr), .rxd(rxd), .txd(txd),
    .rd_data(rd_data), .ti(ti), .ri(ri), .irq(irq)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_div, m_tt, m_n;
  bit m_q[$];
  bit m_v[$];
  bit m_h1, m_h2, m_last, m_act, m_ti, m_ri, tk, x, m_in, tset, rset, exp_txd;
  logic [7:0] m_b, m_rd;

  always_comb exp_txd = (m_q.size() > 0) ? m_q[0] : 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_tt = 0; m_n = 0; m_q.delete(); m_v.delete();
      m_h1 = 1; m_h2 = 1; m_last = 1; m_act = 0; m_ti = 0; m_ri = 0;
      m_b = 0; m_rd = 0;
    end else begin
      tset = 0; rset = 0;
      tk = (m_div == CLK_DIV - 1);
      m_div = tk ? 0 : m_div + 1;
      m_in = loop ? exp_txd : rx_drv;
      if (wr_en && m_q.size() == 0) begin
        m_q.push_back(1'b0);
        for (int k = 0; k < 8; k++) m_q.push_back(wr_data[k]);
        m_q.push_back(1'b1);
        m_tt = 0;
      end else if (tk && m_q.size() > 0) begin
        m_tt++;
        if (m_tt == 4) begin
          m_tt = 0;
          void'(m_q.pop_front());
          if (m_q.size() == 0) tset = 1;
        end
      end
      x = m_h2;
      if (tk) begin
        if (!m_act) begin
          if (m_last && !x) begin m_act = 1; m_n = 1; m_v.delete(); end
        end else begin
          int pos, bitno, ones;
          pos = m_n % 4; bitno = m_n / 4;
          if (pos != 0) m_v.push_back(x);
          m_n++;
          if (pos == 3) begin
            ones = 0;
            foreach (m_v[k]) ones += int'(m_v[k]);
            m_v.delete();
            if (bitno == 0 && ones >= 2) m_act = 0;
            else if (bitno >= 1 && bitno <= 8) m_b[bitno-1] = (ones >= 2);
            else if (bitno == 9) begin
              m_act = 0;
              if (ones >= 2) begin m_rd = m_b; rset = 1; end
            end
          end
        end
        m_last = x;
      end
      m_h2 = m_h1; m_h1 = m_in;
      m_ti = tset ? 1'b1 : (ti_clr ? 1'b0 : m_ti);
      m_ri = rset ? 1'b1 : (ri_clr ? 1'b0 : m_ri);
    end
  end

  int ti_hi = 0, ri_hi = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(txd == exp_txd, "R2/R3/R4 txd vs model", txd, exp_txd);
      check(ti == m_ti, "R5/R10 ti vs model", ti, m_ti);
      check(ri == m_ri, "R8/R9/R10 ri vs model", ri, m_ri);
      check(rd_data == m_rd, "R6/R7/R9 rd_data vs model", rd_data, m_rd);
      check(irq == (m_ti | m_ri), "R11 irq vs model", irq, m_ti | m_ri);
      if (ti) ti_hi++;
      if (ri) ri_hi++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr_en = 1; wr_data = d; step(1); wr_en = 0;
  endtask

  task automatic wait_ti();
    for (int k = 0; k < 2000 && !ti; k++) step(1);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit glitch, input bit badstop);
    for (int i = 0; i < 10; i++) begin
      logic v;
      v = (i == 0) ? 1'b0 : (i == 9) ? ~badstop : d[i-1];
      for (int j = 0; j < BITCYC; j++) begin
        rx_drv = (glitch && i == 4 && j >= 4 && j < 4 + CLK_DIV) ? ~v : v;
        step(1);
      end
    end
    rx_drv = 1;
    step(2 * BITCYC);
  endtask

  initial begin
    step(5);
    rst_n = 1;
    step(1);
    check(txd == 1, "R1 txd idle", txd, 1);
    check(ti == 0, "R1 ti", ti, 0);
    check(ri == 0, "R1 ri", ri, 0);
    check(irq == 0, "R1 irq", irq, 0);
    check(rd_data == 0, "R1 rd_data", rd_data, 0);

    write_byte(8'hA5);
    step(20);
    write_byte(8'h3C);               // R4: ignored, frame busy
    wait_ti();
    check(ti == 1, "R5 ti after frame", ti, 1);
    check(irq == 1, "R11 irq from ti", irq, 1);
    ti_clr = 1; step(1); ti_clr = 0;
    step(200);
    check(ti == 0 && txd == 1, "R4 no second frame", {ti, txd}, 1);

    write_byte(8'h01); wait_ti(); ti_clr = 1; step(1); ti_clr = 0;
    write_byte(8'h80); wait_ti(); ti_clr = 1; step(1); ti_clr = 0;

    send_rx(8'h5A, 0, 0);
    check(rd_data == 8'h5A && ri == 1, "R9 byte 5A", rd_data, 8'h5A);
    ri_clr = 1; step(1); ri_clr = 0;
    send_rx(8'h00, 1, 0);
    check(rd_data == 8'h00, "R7 vote with glitch 00", rd_data, 8'h00);
    ri_clr = 1; step(1); ri_clr = 0;
    send_rx(8'hFF, 1, 0);
    check(rd_data == 8'hFF, "R7 vote with glitch FF", rd_data, 8'hFF);
    ri_clr = 1; step(1); ri_clr = 0;
    send_rx(8'h81, 0, 0);
    check(rd_data == 8'h81, "R6 byte 81", rd_data, 8'h81);
    ri_clr = 1; step(1); ri_clr = 0;

    rx_drv = 0; step(CLK_DIV); rx_drv = 1; step(5 * BITCYC);
    check(ri == 0 && rd_data == 8'h81, "R8 short start ignored", rd_data, 8'h81);

    send_rx(8'h33, 0, 1);
    step(BITCYC);
    check(ri == 0 && rd_data == 8'h81, "R9 bad stop dropped", rd_data, 8'h81);

    ti_hi = 0; ti_clr = 1;
    write_byte(8'h96);
    step(20 * BITCYC);
    ti_clr = 0;
    check(ti_hi == 1, "R10 ti set beats clear", ti_hi, 1);

    ri_hi = 0; ri_clr = 1;
    send_rx(8'hC3, 0, 0);
    ri_clr = 0;
    check(ri_hi == 1, "R10 ri set beats clear", ri_hi, 1);
    check(rd_data == 8'hC3, "R9 byte C3", rd_data, 8'hC3);

    loop = 1;
    write_byte(8'hE7);
    step(20 * BITCYC);
    check(rd_data == 8'hE7, "R6 loopback byte", rd_data, 8'hE7);
    check(ti == 1 && ri == 1 && irq == 1, "R11 both flags", {ti, ri, irq}, 7);
    ti_clr = 1; ri_clr = 1; step(1); ti_clr = 0; ri_clr = 0;
    step(1);
    check(irq == 0, "R11 irq cleared", irq, 0);
    loop = 0;
    step(10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule